// File: doc/BRIEF.md
# Serial FIFO Pair with Level Reporting

This block holds the byte queues for one asynchronous serial port: a transmit queue filled by software and drained by the serializer, and a receive queue filled by the deserializer and drained by software. Each queue holds 16 bytes. Software reaches both queues, their control fields, a packed occupancy word and the interrupt registers through a small word-addressed register port. The serial side uses two one-cycle handshakes: a take strobe pulls the oldest transmit byte, and a put strobe offers one received byte.

Each queue has its own control word. It holds an enable, a flush bit that clears itself, and a 6-bit trigger level. The receive request is raised when enough bytes have gathered. The transmit request is raised when the transmit queue has drained to its trigger level or below. A receive overrun raises an error request. A separate transmit-buffer request follows an empty transmit queue. Request bits are sticky and are cleared by writing ones. Each interrupt line is a request bit gated by its enable bit.

Register word addresses: 0 transmit data (write), 1 receive data (read), 2 transmit control, 3 receive control, 4 status, 5 interrupt enable, 6 pending.

Top module: `sfp_fifo_pair`

## Requirements
- R1: After reset, status reads 0x1000_0000 (transmit free count 16, both fill levels 0). Both control words, the interrupt enable and the pending register read 0, and all interrupt lines are low.
- R2: A write to address 0 with the transmit queue enabled and not full stores wdata[7:0]. The serial side receives bytes in write order: tx_avail is high while the queue holds a byte, tx_data shows the oldest byte, and tx_take pops it.
- R3: A write to address 0 while the transmit free count is zero is dropped, and the fill level stays unchanged.
- R4: rx_put with the receive queue enabled and not full stores rx_data. A read of address 1 returns the oldest byte in rdata[7:0] and removes it.
- R5: A read of address 1 while the receive fill level is zero returns 0 and leaves the status unchanged.
- R6: The status word at address 4 carries the receive fill level in bits 5:0, the transmit fill level in bits 13:8 and the transmit free count (16 minus fill) in bits 29:24. All other bits are 0.
- R7: In each control word, bit 0 is the enable, bit 1 is flush and bits 13:8 are the trigger level. Writing bit 1 as 1 empties that queue by the next cycle. The word reads back with bit 1 as 0 and keeps the written enable and trigger.
- R8: While the receive queue is enabled and its fill level is nonzero and at least its trigger level, pending bit 1 is set. irq_rx equals pending bit 1 AND enable bit 1.
- R9: While the transmit queue is enabled and its fill level is at or below its trigger level, pending bit 0 is set. irq_tx equals pending bit 0 AND enable bit 0.
- R10: Pending bits stay set after their condition ends. Writing 1 to a bit of address 6 clears it, unless its condition holds in that same cycle.
- R11: rx_put while the enabled receive queue is full drops the byte and sets pending bit 2. irq_err equals pending bit 2 AND enable bit 2.
- R12: irq_txbuf equals enable bit 3 AND a transmit fill level of zero.
- R13: While a queue's enable bit is 0, writes to address 0 (transmit queue) and rx_put strobes (receive queue) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (a read of address 1 pops) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| tx_take | input | 1 | Serializer pops one transmit byte |
| tx_avail | output | 1 | Transmit queue not empty |
| tx_data | output | 8 | Oldest transmit byte |
| rx_put | input | 1 | Deserializer offers one byte |
| rx_data | input | 8 | Received byte |
| tx_empty | output | 1 | Transmit fill level is zero |
| irq_tx | output | 1 | Transmit level request |
| irq_rx | output | 1 | Receive level request |
| irq_err | output | 1 | Receive overrun request |
| irq_txbuf | output | 1 | Transmit-buffer-empty request |

## Verification
The hardest situation to reach is where the request threshold is crossed exactly. The transmit request must appear at the first pop that brings the fill level down to the trigger level, and not one pop early or late. The receive request must appear at the exact push that reaches the trigger level. The bench sweeps every trigger level from 0 to 16 for both queues. For each level it flushes the queue, refills it or drains it one byte at a time, clears stale pending bits, and after each single step compares the sticky request with an arithmetic prediction.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
    localparam int DEPTH   = 16;
    localparam int DW      = 8;
    localparam int CW      = $clog2(DEPTH + 1);
    localparam int FLD     = 6;

    typedef enum logic [2:0] {
        A_TXD   = 3'd0,
        A_RXD   = 3'd1,
        A_TXCTL = 3'd2,
        A_RXCTL = 3'd3,
        A_STAT  = 3'd4,
        A_IEN   = 3'd5,
        A_PEND  = 3'd6
    } reg_addr_e;

    typedef struct packed {
        logic [FLD-1:0] trig;
        logic           en;
    } qctl_t;

    localparam int B_EN    = 0;
    localparam int B_FLUSH = 1;
    localparam int B_TRIG  = 8;

    function automatic logic [FLD-1:0] widen(input logic [CW-1:0] v);
        return FLD'(v);
    endfunction

    function automatic logic [31:0] pack_status(input logic [CW-1:0] rxn,
                                                input logic [CW-1:0] txn);
        logic [31:0] w;
        w = '0;
        w[5:0]   = widen(rxn);
        w[13:8]  = widen(txn);
        w[29:24] = widen(CW'(DEPTH) - txn);
        return w;
    endfunction

    function automatic logic [31:0] pack_ctl(input qctl_t c);
        logic [31:0] w;
        w = '0;
        w[B_EN] = c.en;
        w[B_TRIG +: FLD] = c.trig;
        return w;
    endfunction
endpackage

// File: rtl/sfp_fifo.sv
module sfp_fifo
    import sfp_pkg::*;
#(
    parameter int N  = DEPTH,
    parameter int W  = DW,
    localparam int PW = (N > 1) ? $clog2(N) : 1,
    localparam int NW = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [NW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [N];
    logic [PW-1:0] wp, rp;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(N - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full  = (count == NW'(N));
    assign empty = (count == '0);
    assign dout  = mem[rp];

    always_ff @(posedge clk) begin
        if (push && !flush) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push) wp <= nxt(wp);
            if (pop)  rp <= nxt(rp);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count <= NW'(N)); // R3
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
        flush |=> (count == '0)); // R7
    AST_PUSH_STEP: assert property (@(posedge clk) disable iff (rst)
        (!flush && push && !pop) |=> (count == $past(count) + 1'b1)); // R2
endmodule

// File: rtl/sfp_irq.sv
module sfp_irq (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] cond,
    input  logic [2:0] w1c,
    input  logic [3:0] ien,
    input  logic       tx_empty,
    output logic [2:0] pend,
    output logic       irq_tx,
    output logic       irq_rx,
    output logic       irq_err,
    output logic       irq_txbuf
);
    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= (pend & ~w1c) | cond;
    end

    assign irq_tx    = pend[0] & ien[0];
    assign irq_rx    = pend[1] & ien[1];
    assign irq_err   = pend[2] & ien[2];
    assign irq_txbuf = ien[3] & tx_empty;

    AST_RX_SET: assert property (@(posedge clk) disable iff (rst)
        cond[1] |=> pend[1]); // R8
    AST_TX_SET: assert property (@(posedge clk) disable iff (rst)
        cond[0] |=> pend[0]); // R9
    AST_STICKY: assert property (@(posedge clk) disable iff (rst)
        (pend[1] && !w1c[1]) |=> pend[1]); // R10
    AST_ERR_GATED: assert property (@(posedge clk) disable iff (rst)
        irq_err |-> ien[2]); // R11
endmodule

// File: rtl/sfp_fifo_pair.sv
module sfp_fifo_pair
    import sfp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic        reg_re,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        tx_take,
    output logic        tx_avail,
    output logic [7:0]  tx_data,
    input  logic        rx_put,
    input  logic [7:0]  rx_data,
    output logic        tx_empty,
    output logic        irq_tx,
    output logic        irq_rx,
    output logic        irq_err,
    output logic        irq_txbuf
);
    qctl_t          txc, rxc;
    logic [3:0]     ien;
    logic [2:0]     pend, cond, w1c;
    logic [CW-1:0]  tx_n, rx_n;
    logic           tx_full, tx_emp, rx_full, rx_emp;
    logic [DW-1:0]  rx_dout;
    logic           wr_tx, wr_rx, wr_txd, rd_rxd;
    logic           tx_flush, rx_flush, tx_push, rx_push, tx_pop, rx_pop;

    assign wr_tx  = reg_we && (reg_addr == A_TXCTL);
    assign wr_rx  = reg_we && (reg_addr == A_RXCTL);
    assign wr_txd = reg_we && (reg_addr == A_TXD);
    assign rd_rxd = reg_re && (reg_addr == A_RXD);

    assign tx_flush = wr_tx && reg_wdata[B_FLUSH];
    assign rx_flush = wr_rx && reg_wdata[B_FLUSH];
    assign tx_push  = wr_txd && txc.en && !tx_full;
    assign tx_pop   = tx_take && !tx_emp;
    assign rx_push  = rx_put && rxc.en && !rx_full;
    assign rx_pop   = rd_rxd && !rx_emp;

    always_ff @(posedge clk) begin
        if (rst) begin
            txc <= '0;
            rxc <= '0;
            ien <= '0;
        end else begin
            if (wr_tx) begin
                txc.en   <= reg_wdata[B_EN];
                txc.trig <= reg_wdata[B_TRIG +: FLD];
            end
            if (wr_rx) begin
                rxc.en   <= reg_wdata[B_EN];
                rxc.trig <= reg_wdata[B_TRIG +: FLD];
            end
            if (reg_we && (reg_addr == A_IEN)) ien <= reg_wdata[3:0];
        end
    end

    sfp_fifo #(.N(DEPTH), .W(DW)) u_txq (
        .clk(clk), .rst(rst), .flush(tx_flush), .push(tx_push),
        .din(reg_wdata[DW-1:0]), .pop(tx_pop), .dout(tx_data),
        .count(tx_n), .full(tx_full), .empty(tx_emp)
    );

    sfp_fifo #(.N(DEPTH), .W(DW)) u_rxq (
        .clk(clk), .rst(rst), .flush(rx_flush), .push(rx_push),
        .din(rx_data), .pop(rx_pop), .dout(rx_dout),
        .count(rx_n), .full(rx_full), .empty(rx_emp)
    );

    assign cond[0] = txc.en && (widen(tx_n) <= txc.trig);
    assign cond[1] = rxc.en && (rx_n != '0) && (widen(rx_n) >= rxc.trig);
    assign cond[2] = rx_put && rxc.en && rx_full;
    assign w1c     = (reg_we && (reg_addr == A_PEND)) ? reg_wdata[2:0] : 3'b000;

    sfp_irq u_irq (
        .clk(clk), .rst(rst), .cond(cond), .w1c(w1c), .ien(ien),
        .tx_empty(tx_emp), .pend(pend), .irq_tx(irq_tx), .irq_rx(irq_rx),
        .irq_err(irq_err), .irq_txbuf(irq_txbuf)
    );

    assign tx_avail = !tx_emp;
    assign tx_empty = tx_emp;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_RXD:   reg_rdata[DW-1:0] = rx_emp ? '0 : rx_dout;
            A_TXCTL: reg_rdata = pack_ctl(txc);
            A_RXCTL: reg_rdata = pack_ctl(rxc);
            A_STAT:  reg_rdata = pack_status(rx_n, tx_n);
            A_IEN:   reg_rdata[3:0] = ien;
            A_PEND:  reg_rdata[2:0] = pend;
            default: reg_rdata = '0;
        endcase
    end

    AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
        (wr_txd && tx_full && !tx_take && !tx_flush) |=> $stable(tx_n)); // R3
    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_rxd && rx_emp) |-> (reg_rdata == 32'd0)); // R5
    AST_DISABLED_RX: assert property (@(posedge clk) disable iff (rst)
        (!rxc.en && !rd_rxd && !rx_flush) |=> $stable(rx_n)); // R13
    AST_EMPTY_FLAG: assert property (@(posedge clk) disable iff (rst)
        tx_empty |-> !tx_avail); // R12
endmodule

// File: tb/test_sfp_fifo_pair.sv
module test_sfp_fifo_pair;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0, reg_re = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tx_take = 1'b0, rx_put = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        tx_avail, tx_empty, irq_tx, irq_rx, irq_err, irq_txbuf;
    logic [7:0]  tx_data;

    int checks = 0, fails = 0, cyc = 0;
    logic [31:0] rv;

    always #2.5 clk = ~clk;

    sfp_fifo_pair i_sfp_fifo_pair (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_take(tx_take), .tx_avail(tx_avail), .tx_data(tx_data),
        .rx_put(rx_put), .rx_data(rx_data), .tx_empty(tx_empty),
        .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_err(irq_err), .irq_txbuf(irq_txbuf)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] stat(input int rxn, input int txn);
        return (32'(16 - txn) << 24) | (32'(txn) << 8) | 32'(rxn);
    endfunction

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 5) & 255);
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_re = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_re = 1'b0;
    endtask

    task automatic put(input logic [7:0] b);
        rx_put = 1'b1; rx_data = b;
        @(negedge clk);
        rx_put = 1'b0;
    endtask

    task automatic take(output logic [7:0] b, output logic v);
        tx_take = 1'b1;
        #1 b = tx_data; v = tx_avail;
        @(negedge clk);
        tx_take = 1'b0;
    endtask

    initial begin
        while (cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        fails++;
        $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] b;
        logic v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(3'd4, rv); chk("R1 status", rv, 32'h1000_0000);
        rd(3'd2, rv); chk("R1 txctl", rv, 0);
        rd(3'd3, rv); chk("R1 rxctl", rv, 0);
        rd(3'd6, rv); chk("R1 pend", rv, 0);
        chk("R1 irqs", {28'd0, irq_tx, irq_rx, irq_err, irq_txbuf}, 0);

        // R13 disabled queues ignore pushes
        wr(3'd0, 32'h55); put(8'h66);
        rd(3'd4, rv); chk("R13 disabled", rv, stat(0, 0));

        // enable: tx trig 0, rx trig 4, all interrupt enables
        wr(3'd2, 32'h0000_0001);
        wr(3'd3, 32'h0000_0401);
        wr(3'd5, 32'hF);
        tick();
        chk("R12 txbuf empty", 32'(irq_txbuf), 1);
        chk("R9 tx req at level 0", 32'(irq_tx), 1);

        // R2 R3 R6 fill sweep
        for (int k = 1; k <= 18; k++) begin
            wr(3'd0, 32'(pat(k)));
            rd(3'd4, rv);
            chk("R6 R3 tx fill", rv, stat(0, (k > 16) ? 16 : k));
        end
        tick();
        chk("R12 txbuf nonempty", 32'(irq_txbuf), 0);
        wr(3'd6, 32'h1); tick();
        rd(3'd6, rv); chk("R10 w1c tx", rv & 1, 0);
        for (int k = 1; k <= 16; k++) begin
            take(b, v);
            chk("R2 tx order", {23'd0, v, b}, {23'd0, 1'b1, pat(k)});
        end
        take(b, v);
        chk("R2 tx avail low", 32'(v), 0);
        tick();
        rd(3'd6, rv); chk("R9 tx re-raise", rv & 1, 1);
        chk("R9 irq_tx", 32'(irq_tx), 1);

        // R4 R8 R11 receive sweep
        wr(3'd6, 32'h7);
        for (int k = 1; k <= 17; k++) begin
            put(pat(k + 40));
            tick();
            rd(3'd4, rv); chk("R6 R4 rx fill", rv, stat((k > 16) ? 16 : k, 0));
            rd(3'd6, rv);
            chk("R8 R11 rx pend", rv & 6, {29'd0, k > 16, k >= 4, 1'b0});
        end
        chk("R11 irq_err", 32'(irq_err), 1);
        chk("R8 irq_rx", 32'(irq_rx), 1);
        for (int k = 1; k <= 16; k++) begin
            rd(3'd1, rv); chk("R4 rx order", rv, 32'(pat(k + 40)));
        end
        rd(3'd1, rv); chk("R5 empty read", rv, 0);
        rd(3'd4, rv); chk("R5 empty status", rv, stat(0, 0));
        rd(3'd6, rv); chk("R10 sticky", rv & 6, 6);
        wr(3'd6, 32'h6); tick();
        rd(3'd6, rv); chk("R10 cleared", rv & 6, 0);

        // R7 flush
        for (int k = 0; k < 5; k++) wr(3'd0, 32'(k));
        for (int k = 0; k < 3; k++) put(8'(k));
        wr(3'd2, 32'h0000_0203);
        rd(3'd4, rv); chk("R7 tx flush", rv, stat(3, 0));
        rd(3'd2, rv); chk("R7 tx readback", rv, 32'h0000_0201);
        wr(3'd3, 32'h0000_0503);
        rd(3'd4, rv); chk("R7 rx flush", rv, stat(0, 0));
        rd(3'd3, rv); chk("R7 rx readback", rv, 32'h0000_0501);

        // R9 tx threshold sweep
        for (int t = 0; t <= 16; t++) begin
            wr(3'd2, 32'h3 | (32'(t) << 8));
            for (int k = 0; k < 16; k++) wr(3'd0, 32'(k));
            wr(3'd6, 32'h1); tick();
            rd(3'd6, rv); chk("R9 tx sweep full", rv & 1, (t >= 16) ? 1 : 0);
            for (int n = 15; n >= 0; n--) begin
                take(b, v); tick();
                rd(3'd6, rv);
                chk("R9 tx sweep", rv & 1, (n <= t) ? 1 : 0);
            end
        end

        // R8 rx threshold sweep
        for (int t = 0; t <= 16; t++) begin
            wr(3'd3, 32'h3 | (32'(t) << 8));
            wr(3'd6, 32'h2); tick();
            rd(3'd6, rv); chk("R8 rx sweep empty", rv & 2, 0);
            for (int n = 1; n <= 16; n++) begin
                put(8'(n)); tick();
                rd(3'd6, rv);
                chk("R8 rx sweep", rv & 2, (n >= t) ? 2 : 0);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule